// File: doc/BRIEF.md
# Time-Division Tile Router with Stored Schedule

This block is the communication interface of one tile in a mesh where tiles talk only to their four nearest neighbours. It has five input lanes and five output lanes: North, South, East, West and the local core. Each lane carries a data word and a valid bit. Routing is not decided per packet. A small schedule memory holds a fixed table of crossbar settings. A slot counter steps through that table one entry per interconnect cycle and replays it without end. In every cycle the current entry connects inputs to outputs, and one input may feed several outputs at the same time.

The schedule is loaded and changed by configuration words on a dedicated stream, which the tile delivers in time slots alongside the data streams. A write command stores one table entry. A rebase command picks the start address of the schedule to run. The first rebase after reset starts the router. A later rebase is held back until the running schedule reaches its end-marked slot, so a schedule pass is never cut short. All outputs are registered. A word moves one hop per cycle, so a stream from a core, through one tile, into a third core takes three cycles.

Top module: `tdm_tile_router`

## Requirements
- R1: While reset is high, and after reset until the first rebase command, every out_valid bit is 0. At reset out_data is cleared to 0.
- R2: A schedule entry holds a 3-bit source select per output. Output o occupies entry bits [3o+2:3o]. Outputs and sources use the same index: 0 North, 1 South, 2 East, 3 West, 4 Core. When the slot at the counter selects source s and in_valid[s] is 1, output o shows in_data of lane s with valid 1 after the next rising edge.
- R3: One source may be selected by any number of outputs in the same slot, and each of those outputs receives the same word.
- R4: A select of 7 (idle), or the unused values 5 and 6, drives that output's valid to 0 and leaves its data unchanged.
- R5: When the selected source has in_valid 0, the output's valid is 0 and its data is unchanged.
- R6: While running, the counter advances by one per cycle. It wraps from the top of the memory to address 0. In a slot whose bit 15 (the end flag) is set, it reloads the current schedule base instead.
- R7: A configuration word has opcode bits [21:20], address bits [19:16] and entry bits [15:0]. With cfg_valid high, opcode 1 writes the entry field to the addressed table slot.
- R8: A write to the slot being executed in the same cycle does not change that cycle's routing. It takes effect on the next visit to that slot.
- R9: While running, opcode 2 (rebase) does not change the counter's stepping until the next end-flagged slot. At that slot, which may be the command cycle itself, the counter and the base both load the new address. If several rebases arrive before the end slot, the last one wins.
- R10: The first rebase after reset starts the schedule. The slot at its address is executed in the next cycle.
- R11: Opcodes 0 and 3, and any word with cfg_valid low, change neither the table nor the schedule base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 80 | Input words, lane p at bits [16p+15:16p] (0 N, 1 S, 2 E, 3 W, 4 Core) |
| in_valid | input | 5 | Input valid per lane |
| cfg_valid | input | 1 | Configuration word present |
| cfg_word | input | 22 | Configuration word: opcode, address, entry |
| out_data | output | 80 | Registered output words, same lane layout as in_data |
| out_valid | output | 5 | Registered output valid per lane |

## Verification
The bench targets four corner cases:
- Idle, unused and not-valid selects. A design that let data through there would show toggling output words on disabled streams.
- A rebase in the middle of a schedule, and a rebase that lands on the end slot itself. A design that applied the base at once would jump partway through a pass. One that ignored a same-cycle rebase would run one extra pass of the old table.
- A write to the slot now executing. This catches a design that forwards new entries too early.
- The ignored opcodes and gated words. This catches a decoder that matches on too few bits or misses cfg_valid.

A random phase then mixes these commands with random traffic and valid patterns. It includes schedules with no end flag, which wrap at the top of the memory.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NPORT   = 5;
  localparam int SEL_W   = 3;
  localparam int OPC_W   = 2;
  localparam int ENTRY_W = NPORT * SEL_W + 1;

  typedef enum logic [SEL_W-1:0] {
    P_NORTH = 3'd0,
    P_SOUTH = 3'd1,
    P_EAST  = 3'd2,
    P_WEST  = 3'd3,
    P_CORE  = 3'd4,
    P_IDLE  = 3'd7
  } port_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_BASE  = 2'd2,
    OP_RSVD  = 2'd3
  } opc_e;
endpackage

// File: rtl/tdm_sched_mem.sv
module tdm_sched_mem #(
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] table_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) table_q[waddr] <= wdata;
  end

  assign rdata = table_q[raddr];
endmodule

// File: rtl/tdm_seq_ctrl.sv
module tdm_seq_ctrl
  import tdm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 16,
  parameter int CFG_W   = OPC_W + ADDR_W + ENTRY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_valid,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic               end_flag,
  output logic [ADDR_W-1:0]  pc,
  output logic               armed,
  output logic               tbl_we,
  output logic [ADDR_W-1:0]  tbl_waddr,
  output logic [ENTRY_W-1:0] tbl_wdata
);
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] cmd_addr;
  logic              is_base;
  logic [ADDR_W-1:0] base_q, pend_q, next_base;
  logic              pend_f;

  assign opc       = cfg_word[CFG_W-1 -: OPC_W];
  assign cmd_addr  = cfg_word[ENTRY_W +: ADDR_W];
  assign tbl_wdata = cfg_word[ENTRY_W-1:0];
  assign tbl_waddr = cmd_addr;
  assign tbl_we    = cfg_valid && (opc == OP_WRITE);
  assign is_base   = cfg_valid && (opc == OP_BASE);

  always_comb begin
    if (is_base)     next_base = cmd_addr;
    else if (pend_f) next_base = pend_q;
    else             next_base = base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      base_q <= '0;
      pend_q <= '0;
      pend_f <= 1'b0;
      armed  <= 1'b0;
    end else if (!armed) begin
      if (is_base) begin
        armed  <= 1'b1;
        base_q <= cmd_addr;
        pc     <= cmd_addr;
      end
    end else if (end_flag) begin
      pc     <= next_base;
      base_q <= next_base;
      pend_f <= 1'b0;
    end else begin
      pc <= pc + ADDR_W'(1);
      if (is_base) begin
        pend_q <= cmd_addr;
        pend_f <= 1'b1;
      end
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && !end_flag) |=> (pc == $past(pc) + ADDR_W'(1))); // R6
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed && !end_flag) |=> $stable(base_q)); // R9
endmodule

// File: rtl/tdm_xbar.sv
module tdm_xbar
  import tdm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [NPORT*SEL_W-1:0]  sel_flat,
  input  logic [NPORT*DATA_W-1:0] in_data,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT*DATA_W-1:0] out_data,
  output logic [NPORT-1:0]        out_valid
);
  logic [NPORT-1:0]  hit;
  logic [DATA_W-1:0] pick [NPORT];

  for (genvar o = 0; o < NPORT; o++) begin : g_lane
    logic [SEL_W-1:0] s;
    logic             in_range;
    logic [SEL_W-1:0] si;
    assign s        = sel_flat[o*SEL_W +: SEL_W];
    assign in_range = (s < SEL_W'(NPORT));
    assign si       = in_range ? s : '0;
    assign hit[o]   = run && in_range && in_valid[si];
    assign pick[o]  = in_data[int'(si)*DATA_W +: DATA_W];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !out_valid[o] |-> $stable(out_data[o*DATA_W +: DATA_W])); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        out_valid[o] <= hit[o];
        if (hit[o]) out_data[o*DATA_W +: DATA_W] <= pick[o];
      end
    end
  end

  AST_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (out_valid == '0)); // R1
endmodule

// File: rtl/tdm_tile_router.sv
module tdm_tile_router
  import tdm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NPORT*DATA_W-1:0]              in_data,
  input  logic [NPORT-1:0]                     in_valid,
  input  logic                                 cfg_valid,
  input  logic [OPC_W+ADDR_W+ENTRY_W-1:0]      cfg_word,
  output logic [NPORT*DATA_W-1:0]              out_data,
  output logic [NPORT-1:0]                     out_valid
);
  localparam int CFG_W = OPC_W + ADDR_W + ENTRY_W;

  logic [ADDR_W-1:0]  pc;
  logic               armed;
  logic               tbl_we;
  logic [ADDR_W-1:0]  tbl_waddr;
  logic [ENTRY_W-1:0] tbl_wdata;
  logic [ENTRY_W-1:0] slot;

  tdm_sched_mem #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_mem (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (pc),
    .rdata (slot)
  );

  tdm_seq_ctrl #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cfg_word  (cfg_word),
    .end_flag  (slot[ENTRY_W-1]),
    .pc        (pc),
    .armed     (armed),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .tbl_wdata (tbl_wdata)
  );

  tdm_xbar #(.DATA_W(DATA_W)) u_xbar (
    .clk       (clk),
    .rst       (rst),
    .run       (armed),
    .sel_flat  (slot[ENTRY_W-2:0]),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: tb/sim_tdm_tile_router.sv
module sim_tdm_tile_router;
  import tdm_pkg::*;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int EW     = NPORT * SEL_W + 1;
  localparam int CFG_W  = OPC_W + ADDR_W + EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NPORT*DATA_W-1:0] in_data   = '0;
  logic [NPORT-1:0]        in_valid  = '0;
  logic                    cfg_valid = 1'b0;
  logic [CFG_W-1:0]        cfg_word  = '0;
  logic [NPORT*DATA_W-1:0] out_data;
  logic [NPORT-1:0]        out_valid;

  tdm_tile_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .out_data(out_data), .out_valid(out_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [EW-1:0]           m_mem [DEPTH];
  int                      m_pc = 0, m_base = 0, m_pend = 0;
  bit                      m_pendf = 0, m_armed = 0;
  logic [NPORT*DATA_W-1:0] exp_d = '0;
  logic [NPORT-1:0]        exp_v = '0;

  function automatic logic [EW-1:0] ent(int n, int s, int e, int w, int c, bit endf);
    return {endf, 3'(c), 3'(w), 3'(e), 3'(s), 3'(n)};
  endfunction

  function automatic logic [CFG_W-1:0] word(int op, int a, logic [EW-1:0] en);
    return {2'(op), 4'(a), en};
  endfunction

  task automatic check(string tag);
    checks++;
    if (out_valid !== exp_v || out_data !== exp_d) begin
      fails++;
      $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
               tag, out_valid, out_data, exp_v, exp_d);
    end
  endtask

  task automatic randin(bit allvalid);
    for (int p = 0; p < NPORT; p++) in_data[p*DATA_W +: DATA_W] = DATA_W'($urandom);
    in_valid = allvalid ? '1 : NPORT'($urandom);
  endtask

  // model one cycle from the requirements, then clock and compare
  task automatic cyc(string tag);
    logic [EW-1:0] e;
    int op, a, nb;
    bit isw, isb;
    e = '0;
    if (m_armed) begin
      e = m_mem[m_pc];
      for (int o = 0; o < NPORT; o++) begin
        int s = int'(e[o*SEL_W +: SEL_W]);
        if (s < NPORT && in_valid[s]) begin
          exp_v[o] = 1'b1;
          exp_d[o*DATA_W +: DATA_W] = in_data[s*DATA_W +: DATA_W];
        end else exp_v[o] = 1'b0;
      end
    end else exp_v = '0;
    op  = int'(cfg_word[CFG_W-1 -: OPC_W]);
    a   = int'(cfg_word[EW +: ADDR_W]);
    isw = cfg_valid && op == 1;
    isb = cfg_valid && op == 2;
    if (!m_armed) begin
      if (isb) begin m_armed = 1; m_base = a; m_pc = a; end
    end else if (e[EW-1]) begin
      nb = isb ? a : (m_pendf ? m_pend : m_base);
      m_pc = nb; m_base = nb; m_pendf = 0;
    end else begin
      m_pc = (m_pc + 1) % DEPTH;
      if (isb) begin m_pend = a; m_pendf = 1; end
    end
    if (isw) m_mem[a] = cfg_word[EW-1:0];
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic cfg(int op, int a, logic [EW-1:0] en, string tag);
    cfg_valid = 1'b1;
    cfg_word  = word(op, a, en);
    cyc(tag);
    cfg_valid = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [EW-1:0] sched [DEPTH];
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst = 1'b0;

    sched[0] = ent(4, 3, 0, 1, 2, 0);
    sched[1] = ent(4, 7, 4, 4, 7, 0);   // multicast core, R3
    sched[2] = ent(5, 6, 3, 7, 0, 0);   // unused and idle selects, R4
    sched[3] = ent(7, 7, 7, 7, 3, 1);
    sched[4] = ent(0, 0, 0, 0, 0, 0);
    sched[5] = ent(7, 7, 3, 7, 7, 0);
    sched[6] = ent(7, 7, 7, 7, 3, 1);
    for (int i = 7; i < DEPTH; i++)
      sched[i] = ent($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, i == 15);

    // table load while stopped: outputs must stay idle (R1, R7)
    for (int i = 0; i < DEPTH; i++) begin
      randin(1);
      cfg(1, i, sched[i], "R1 unarmed");
    end
    for (int i = 0; i < 3; i++) begin randin(1); cyc("R1 unarmed"); end

    randin(1);
    cfg(2, 0, '0, "R10 start");
    for (int i = 0; i < 8; i++) begin randin(1); cyc("R2 R3 R4 R6 route"); end
    for (int i = 0; i < 8; i++) begin randin(0); cyc("R5 invalid source"); end

    // deferred rebase issued mid pass (R9)
    while (m_pc != 1) begin randin(1); cyc("R6 align"); end
    randin(1);
    cfg(2, 4, '0, "R9 rebase mid");
    for (int i = 0; i < 8; i++) begin randin(1); cyc("R9 after rebase"); end
    // rebase in the end slot itself
    while (m_pc != 6) begin randin(1); cyc("R6 align"); end
    randin(1);
    cfg(2, 0, '0, "R9 rebase on end");
    for (int i = 0; i < 6; i++) begin randin(1); cyc("R9 after end rebase"); end

    // write to executing slot (R8)
    randin(1);
    cfg(1, m_pc, ent(4, 4, 4, 4, 4, m_mem[m_pc][EW-1]), "R8 write live slot");
    for (int i = 0; i < 8; i++) begin randin(1); cyc("R8 next visit"); end

    // ignored words (R11)
    randin(1); cfg(0, 0, ent(7, 7, 7, 7, 7, 1), "R11 nop");
    randin(1); cfg(3, 1, ent(7, 7, 7, 7, 7, 1), "R11 reserved");
    randin(1);
    cfg_word = word(1, 2, ent(7, 7, 7, 7, 7, 1));
    cyc("R11 gated");
    cfg_word = word(2, 9, '0);
    cyc("R11 gated");
    for (int i = 0; i < 10; i++) begin randin(1); cyc("R11 unchanged"); end

    // random mix
    for (int i = 0; i < 600; i++) begin
      randin($urandom % 2);
      if ($urandom % 8 == 0) begin
        cfg_valid = 1'b1;
        cfg_word  = word($urandom % 4, $urandom % DEPTH, EW'($urandom));
      end
      cyc("R4 R6 R7 random");
      cfg_valid = 1'b0;
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule